// File: doc/BRIEF.md
# Bus Access Activity Decoder

This block watches completed bus cycles and sorts each access into a device category: keyboard, serial, parallel, video, disk/floppy or bus-master/DMA. It decodes each category from fixed legacy address windows. One extra status bit records rising edges of a primary-interrupt activity flag. Each category sets its own sticky bit in a shared status vector. Software clears those bits by writing ones to them.

Two masks decide which categories wake the power-management timers. The primary-enable mask gates a one-cycle primary-event pulse, which reloads the standby timer. The reload mask gates a one-cycle peripheral-event pulse, which reloads the peripheral timer. Only the keyboard, serial, video and disk/floppy categories can feed the peripheral path. The bus protocol stays outside the block: the bus side only presents a valid strobe, an I/O-or-memory flag and the address.

Top module: `bus_activity_decoder`

## Requirements
- R1: While rst_ni is low and on the first clock after release, sts_o, pri_evt_o and per_evt_o are all zero.
- R2: A valid I/O access to address 0060h sets status bit 7 (keyboard). A memory access to the same address does not set it.
- R3: A valid I/O access to 2E8h–2EFh, 2F8h–2FFh, 3E8h–3EFh or 3F8h–3FFh sets status bit 6 (serial).
- R4: A valid I/O access to 278h–27Fh or 378h–37Fh sets status bit 5 (parallel).
- R5: A valid I/O access to 3B0h–3DFh sets status bit 4 (video). So does a valid memory access to A0000h–BFFFFh. I/O decoding uses only the low 16 address bits.
- R6: A valid I/O access to 170h–177h, 1F0h–1F7h or 3F5h sets status bit 3 (disk/floppy).
- R7: A rising edge of dma_active_i sets status bit 0. A rising edge of pirq_act_i sets status bit 1. Holding either input high sets nothing more. Status bit 2 always reads 0.
- R8: Status bits are set whatever the masks hold, and stay set until sts_clr_i writes a 1 to that bit position. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: pri_evt_o pulses high for exactly the one cycle after an event whose category bit is 1 in pri_en_i.
- R10: per_evt_o pulses high for exactly the one cycle after an event whose category bit is 1 in rld_en_i. Only bits 7, 6, 4 and 3 of rld_en_i take effect.
- R11: A cycle with cyc_valid_i low decodes no address and produces no address-based status bit or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_valid_i | input | 1 | A completed bus cycle is presented |
| cyc_io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_addr_i | input | ADDR_W | Cycle address |
| dma_active_i | input | 1 | Bus-master or DMA activity level |
| pirq_act_i | input | 1 | Primary-interrupt activity level |
| pri_en_i | input | 8 | Primary-event enable per category |
| rld_en_i | input | 8 | Peripheral-reload enable per category |
| sts_clr_i | input | 8 | Write-one-to-clear strobe for the status bits |
| sts_o | output | 8 | Sticky activity status |
| pri_evt_o | output | 1 | Primary-event pulse |
| per_evt_o | output | 1 | Peripheral-event pulse |

## Verification
The bench probes the window edges on both sides: 2F7h/2F8h, 3AFh/3B0h, 3DFh/3E0h, 3F4h/3F5h/3F6h, and 9FFFFh/A0000h/BFFFFh/C0000h. An off-by-one comparator would set a bit one address early or leave a boundary address unseen. Memory cycles to I/O-looking addresses test the decoder; one that ignored the I/O flag would flag keyboard or serial activity on memory traffic. A bench setting the parallel and DMA bits of the reload mask checks for a leaking peripheral pulse, and a DMA level held high checks for repeated events. A clear and a new access to the same bit in one cycle catch a status register that lets the clear win and drops the event.

// File: rtl/bad_pkg.sv
package bad_pkg;
  localparam int unsigned NCAT    = 8;
  localparam int unsigned CAT_KBD = 7;
  localparam int unsigned CAT_SER = 6;
  localparam int unsigned CAT_PAR = 5;
  localparam int unsigned CAT_VID = 4;
  localparam int unsigned CAT_DSK = 3;
  localparam int unsigned CAT_RSV = 2;
  localparam int unsigned CAT_IRQ = 1;
  localparam int unsigned CAT_DMA = 0;
  // categories allowed to reload the peripheral timer
  localparam logic [NCAT-1:0] PER_OK = 8'b1101_1000;

  typedef logic [NCAT-1:0] cat_t;

  function automatic logic in_win16(input logic [15:0] a, input logic [15:0] lo,
                                    input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/bad_addr_decode.sv
module bad_addr_decode
  import bad_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter logic [31:0] MEM_LO  = 32'h000A_0000,
  parameter logic [31:0] MEM_HI  = 32'h000B_FFFF
) (
  input  logic              valid_i,
  input  logic              io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cat_t              hit_o
);
  localparam int unsigned IO_W  = 16;
  localparam int unsigned NSER  = 4;
  localparam int unsigned NPAR  = 2;
  localparam logic [15:0] SER_BASE [NSER] = '{16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8};
  localparam logic [15:0] PAR_BASE [NPAR] = '{16'h0378, 16'h0278};

  logic [IO_W-1:0] io_a;
  logic            io_cyc, mem_cyc;
  logic [NSER-1:0] ser_m;
  logic [NPAR-1:0] par_m;

  assign io_a    = addr_i[IO_W-1:0];
  assign io_cyc  = valid_i && io_i;
  assign mem_cyc = valid_i && !io_i;

  for (genvar g = 0; g < NSER; g++) begin : g_ser
    assign ser_m[g] = in_win16(io_a, SER_BASE[g], SER_BASE[g] + 16'h7);
  end
  for (genvar g = 0; g < NPAR; g++) begin : g_par
    assign par_m[g] = in_win16(io_a, PAR_BASE[g], PAR_BASE[g] + 16'h7);
  end

  always_comb begin
    hit_o          = '0;
    hit_o[CAT_KBD] = io_cyc && (io_a == 16'h0060);
    hit_o[CAT_SER] = io_cyc && (|ser_m);
    hit_o[CAT_PAR] = io_cyc && (|par_m);
    hit_o[CAT_VID] = (io_cyc && in_win16(io_a, 16'h03B0, 16'h03DF)) ||
                     (mem_cyc && (addr_i >= ADDR_W'(MEM_LO)) && (addr_i <= ADDR_W'(MEM_HI)));
    hit_o[CAT_DSK] = io_cyc && (in_win16(io_a, 16'h01F0, 16'h01F7) ||
                                in_win16(io_a, 16'h0170, 16'h0177) ||
                                (io_a == 16'h03F5));
  end
endmodule

// File: rtl/bad_edge_det.sv
module bad_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] && !lvl_q[g];
  end
endmodule

// File: rtl/bad_status.sv
module bad_status
  import bad_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cat_t set_i,
  input  cat_t clr_i,
  output cat_t sts_o
);
  cat_t sts_q;

  for (genvar g = 0; g < NCAT; g++) begin : g_bit
    if (g == CAT_RSV) begin : g_rsv
      assign sts_q[g] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sts_q[g] <= 1'b0;
        else if (set_i[g]) sts_q[g] <= 1'b1;   // set beats clear
        else if (clr_i[g]) sts_q[g] <= 1'b0;
      end
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/bus_activity_decoder.sv
module bus_activity_decoder
  import bad_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_valid_i,
  input  logic              cyc_io_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              dma_active_i,
  input  logic              pirq_act_i,
  input  logic [7:0]        pri_en_i,
  input  logic [7:0]        rld_en_i,
  input  logic [7:0]        sts_clr_i,
  output logic [7:0]        sts_o,
  output logic              pri_evt_o,
  output logic              per_evt_o
);
  cat_t       addr_hit, evt_set;
  logic [1:0] lvl_rise;
  logic       pri_q, per_q;

  bad_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (cyc_valid_i),
    .io_i    (cyc_io_i),
    .addr_i  (cyc_addr_i),
    .hit_o   (addr_hit)
  );

  bad_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({pirq_act_i, dma_active_i}),
    .rise_o (lvl_rise)
  );

  always_comb begin
    evt_set          = addr_hit;
    evt_set[CAT_DMA] = lvl_rise[0];
    evt_set[CAT_IRQ] = lvl_rise[1];
  end

  bad_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (sts_clr_i),
    .sts_o  (sts_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      pri_q <= |(evt_set & pri_en_i);
      per_q <= |(evt_set & rld_en_i & PER_OK);
    end
  end

  assign pri_evt_o = pri_q;
  assign per_evt_o = per_q;
endmodule

// File: rtl/bad_checker.sv
module bad_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_valid_i,
  input logic              cyc_io_i,
  input logic [ADDR_W-1:0] cyc_addr_i,
  input logic              dma_active_i,
  input logic              pirq_act_i,
  input logic [7:0]        pri_en_i,
  input logic [7:0]        rld_en_i,
  input logic [7:0]        sts_clr_i,
  input logic [7:0]        sts_o,
  input logic              pri_evt_o,
  input logic              per_evt_o
);
  p_rsv_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[2] == 1'b0);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(sts_o) & ~$past(sts_clr_i)) & ~sts_o) == 8'h00));

  p_pri_backed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_evt_o |-> ((sts_o & $past(pri_en_i)) != 8'h00));

  p_per_backed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_evt_o |-> ((sts_o & $past(rld_en_i) & 8'hD8) != 8'h00));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cyc_valid_i && !dma_active_i && !pirq_act_i) |-> (!pri_evt_o && !per_evt_o));
endmodule

bind bus_activity_decoder bad_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bus_activity_decoder_test.sv
`timescale 1ns/1ps
module bus_activity_decoder_test;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0, io = 1'b0, dma = 1'b0, irq = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    pen = '0, ren = '0, clr = '0;
  logic [7:0]    sts;
  logic          pri, per;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_sts = '0;
  logic       m_pri = 1'b0, m_per = 1'b0, m_dma = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  bus_activity_decoder #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_valid_i(vld), .cyc_io_i(io),
    .cyc_addr_i(addr), .dma_active_i(dma), .pirq_act_i(irq),
    .pri_en_i(pen), .rld_en_i(ren), .sts_clr_i(clr),
    .sts_o(sts), .pri_evt_o(pri), .per_evt_o(per)
  );

  function automatic logic [7:0] ref_cat(input logic v, input logic i, input logic [AW-1:0] a);
    logic [15:0] p;
    logic [7:0]  r;
    p = a[15:0];
    r = '0;
    if (v && i) begin
      r[7] = (p == 16'h60);
      r[6] = (p[15:4] == 12'h3F8 >> 4 && p[3]) || (p[15:4] == 12'h2F && p[3]) ||
             (p[15:4] == 12'h3E && p[3]) || (p[15:4] == 12'h2E && p[3]);
      r[5] = (p >= 16'h378 && p < 16'h380) || (p >= 16'h278 && p < 16'h280);
      r[4] = (p > 16'h3AF && p < 16'h3E0);
      r[3] = (p >= 16'h1F0 && p < 16'h1F8) || (p >= 16'h170 && p < 16'h178) || (p == 16'h3F5);
    end
    if (v && !i) r[4] = (a > 32'h9FFFF && a < 32'hC0000);
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic v, input logic i, input logic [AW-1:0] a,
                      input logic d, input logic q, input logic [7:0] c);
    logic [7:0] s;
    vld = v; io = i; addr = a; dma = d; irq = q; clr = c;
    @(posedge clk);
    s = ref_cat(v, i, a);
    s[0] = d && !m_dma;
    s[1] = q && !m_irq;
    m_dma = d; m_irq = q;
    m_sts = ((m_sts & ~c) | s) & 8'hFB;
    m_pri = |(s & pen);
    m_per = |(s & ren & 8'hD8);
    @(negedge clk);
    chk(tag, "sts", sts, m_sts);
    chk(tag, "pri", {7'd0, pri}, {7'd0, m_pri});
    chk(tag, "per", {7'd0, per}, {7'd0, m_per});
  endtask

  task automatic io_hit(input string tag, input logic [15:0] p);
    step(tag, 1'b1, 1'b1, AW'(p), 1'b0, 1'b0, 8'hFF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [12];
    bases = '{16'h60, 16'h3F8, 16'h2F8, 16'h3E8, 16'h2E8, 16'h378, 16'h278,
              16'h3B0, 16'h3DC, 16'h1F0, 16'h170, 16'h3F5};
    void'($urandom(32'd2024));
    @(negedge clk);
    chk("R1", "sts in reset", sts, 8'h00);
    chk("R1", "pri in reset", {7'd0, pri}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    pen = 8'hFF; ren = 8'hFF;
    step("R1", 1'b0, 1'b0, '0, 1'b0, 1'b0, 8'h00);

    // R2 keyboard; memory to 60h must not count
    io_hit("R2", 16'h0060);
    step("R2", 1'b1, 1'b0, 32'h60, 1'b0, 1'b0, 8'hFF);
    io_hit("R2", 16'h0061);
    // R3 serial edges
    io_hit("R3", 16'h02F7); io_hit("R3", 16'h02F8); io_hit("R3", 16'h03FF);
    io_hit("R3", 16'h03E8); io_hit("R3", 16'h02EF); io_hit("R3", 16'h0400);
    // R4 parallel, and R10: parallel never pulses per
    io_hit("R4", 16'h0377); io_hit("R4", 16'h0378); io_hit("R4", 16'h027F);
    // R5 video I/O and memory
    io_hit("R5", 16'h03AF); io_hit("R5", 16'h03B0); io_hit("R5", 16'h03DF);
    io_hit("R5", 16'h03E0);
    step("R5", 1'b1, 1'b0, 32'h9FFFF, 1'b0, 1'b0, 8'hFF);
    step("R5", 1'b1, 1'b0, 32'hA0000, 1'b0, 1'b0, 8'hFF);
    step("R5", 1'b1, 1'b0, 32'hBFFFF, 1'b0, 1'b0, 8'hFF);
    step("R5", 1'b1, 1'b0, 32'hC0000, 1'b0, 1'b0, 8'hFF);
    step("R5", 1'b1, 1'b1, 32'h001203C0, 1'b0, 1'b0, 8'hFF);
    // R6 disk
    io_hit("R6", 16'h03F4); io_hit("R6", 16'h03F5); io_hit("R6", 16'h03F6);
    io_hit("R6", 16'h01F7); io_hit("R6", 16'h0170); io_hit("R6", 16'h0178);
    // R7 DMA / interrupt edges, held levels
    step("R7", 1'b0, 1'b0, '0, 1'b1, 1'b0, 8'hFF);
    step("R7", 1'b0, 1'b0, '0, 1'b1, 1'b0, 8'hFF);
    step("R7", 1'b0, 1'b0, '0, 1'b1, 1'b1, 8'h00);
    step("R7", 1'b0, 1'b0, '0, 1'b0, 1'b1, 8'h00);
    // R8 set wins against clear; masks off still set status
    pen = 8'h00; ren = 8'h00;
    step("R8", 1'b1, 1'b1, 32'h60, 1'b0, 1'b0, 8'h80);
    step("R8", 1'b1, 1'b1, 32'h3F8, 1'b0, 1'b0, 8'h00);
    step("R8", 1'b0, 1'b0, '0, 1'b0, 1'b0, 8'hFF);
    // R9 / R10 selective masks
    pen = 8'h10; ren = 8'h21;
    step("R9", 1'b1, 1'b1, 32'h3C0, 1'b0, 1'b0, 8'h00);
    step("R9", 1'b0, 1'b0, '0, 1'b0, 1'b0, 8'h00);
    step("R10", 1'b1, 1'b1, 32'h378, 1'b1, 1'b0, 8'h00);
    ren = 8'h08;
    step("R10", 1'b1, 1'b1, 32'h1F3, 1'b0, 1'b0, 8'h00);
    // R11 address ignored without valid
    step("R11", 1'b0, 1'b1, 32'h60, 1'b0, 1'b0, 8'hFF);
    step("R11", 1'b0, 1'b0, 32'hA8000, 1'b0, 1'b0, 8'h00);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      if (n % 50 == 0) begin pen = 8'($urandom); ren = 8'($urandom); end
      if ($urandom % 6 == 0) a = 32'hA0000 + AW'($urandom % 32'h24000) - 32'h2000;
      else if ($urandom % 5 == 0) a = $urandom;
      else a = AW'(bases[$urandom % 12]) + AW'($urandom % 12) - 32'd2;
      step("R2-rand", ($urandom % 4) != 0, ($urandom % 3) != 0, a,
           ($urandom % 5) == 0, ($urandom % 7) == 0,
           (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule